// File: doc/BRIEF.md
# Paged Write Buffer with Commit

This block sits behind a serial command engine and a small byte-wide memory array. It gathers the data bytes of one write command into a page-sized staging buffer. When chip select rises it decides whether the command is committed. A committed command starts a timed write cycle. During the first cycles of that window, the staged bytes are copied into the array. For the whole window the block raises a write-in-progress (busy) flag. The busy window also shuts out array reads and new write or enable commands.

The command engine does the bit shifting and the opcode decoding. It hands this block a start event that carries the starting address, one strobe for each completed data byte, a flag that is high when the bit counter sits on a byte boundary, and a single-cycle pulse when chip select rises. The state of the write-enable latch is an input to this block. The block returns a pulse to set that latch and a pulse to clear it. A page holds 16 bytes, and the whole array holds 128 bytes. Addresses are 7 bits: bits 6..4 select the page and bits 3..0 give the offset inside the page.

Top module: `page_commit_buf`

## Requirements
- R1: While reset is active and after it is released, `wip`, `mem_we` and `wel_clr` are 0 until a write command is committed.
- R2: A `cmd_wr_start` taken while `wel_state` is 0 is discarded. The bytes that follow are never written, and no busy window starts.
- R3: Each data byte is stored at offset (start offset + byte count) mod 16 within the page given by `cmd_addr[6:4]`. The offset wraps from 15 to 0 in the same page, and a later byte overwrites an earlier byte at the same offset.
- R4: The command is committed only if `cs_rise` arrives while `bit_aligned` is 1. A `cs_rise` with `bit_aligned` at 0 ends the command with no array write and no busy window.
- R5: A command that ends with no data bytes starts no busy window and writes nothing.
- R6: During write-back, only the offsets that received a byte are written. Each write uses address {page, offset}, and the offsets come in ascending order.
- R7: After a commit, `wip` rises in the cycle that follows the `cs_rise` cycle and stays high for exactly WR_CYCLES (default 64) cycles.
- R8: `wel_clr` pulses exactly once per busy window, in the last cycle of that window.
- R9: `mem_re` follows `rd_cmd` while `wip` is 0 and stays at 0 while `wip` is 1.
- R10: While `wip` is 1, `wren_cmd` produces no `wel_set`, and `cmd_wr_start`, `byte_valid` and `cs_rise` have no effect. When `wip` is 0, `wel_set` follows `wren_cmd`.
- R11: `mem_we` is asserted only while `wip` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_start | input | 1 | Write command start pulse |
| cmd_addr | input | 7 | Start address, valid with `cmd_wr_start` |
| wel_state | input | 1 | Current state of the write-enable latch |
| byte_valid | input | 1 | One full data byte received |
| byte_in | input | 8 | Data byte, valid with `byte_valid` |
| bit_aligned | input | 1 | Bit counter is on a byte boundary |
| cs_rise | input | 1 | Chip select rose this cycle |
| wren_cmd | input | 1 | Write-enable command decoded |
| rd_cmd | input | 1 | Array read request |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |
| mem_re | output | 1 | Array read strobe, gated by busy |
| wip | output | 1 | Write cycle in progress |
| wel_set | output | 1 | Set the write-enable latch |
| wel_clr | output | 1 | Clear the write-enable latch |

## Verification
The checker enforces the following on every cycle: array writes happen only while busy, reads and enable requests are blocked while busy, a busy window opens only after an aligned chip-select rise, the window lasts exactly the programmed length, the clear pulse is the last busy cycle, and the page part of the write address stays fixed within one window. The bench scenarios are needed for the rest. Only they can show which addresses and data actually reach the array: the in-page wrap, overwriting, sparse write-back, and the fact that unaligned, empty, unenabled and mid-busy commands leave the array untouched.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    PCB_IDLE = 2'd0,
    PCB_FILL = 2'd1,
    PCB_BUSY = 2'd2
  } pcb_state_e;
endpackage

// File: rtl/pcb_rst_sync.sv
module pcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pcb_page_store.sv
module pcb_page_store #(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [OFS_W-1:0]  start_ofs,
  input  logic              store,
  input  logic [DATA_W-1:0] din,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] dout,
  output logic              rd_hit,
  output logic              any_hit
);
  localparam int SLOTS = 1 << OFS_W;

  logic [OFS_W-1:0] ptr_q, ptr_d;
  logic [SLOTS-1:0] hit_q, hit_d;
  logic [SLOTS-1:0] slot_sel;
  logic [DATA_W-1:0] slot_q [SLOTS];

  assign slot_sel = SLOTS'(1) << ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    hit_d = hit_q;
    if (clear) begin
      ptr_d = start_ofs;
      hit_d = '0;
    end else if (store) begin
      ptr_d = ptr_q + 1'b1;
      hit_d = hit_q | slot_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      hit_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      hit_q <= hit_d;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = store && !clear && slot_sel[g];
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= din;
    end
  end

  assign dout    = slot_q[rd_ofs];
  assign rd_hit  = hit_q[rd_ofs];
  assign any_hit = |hit_q;
endmodule

// File: rtl/pcb_commit_ctrl.sv
module pcb_commit_ctrl
  import pcb_pkg::*;
#(
  parameter int WR_CYCLES = 64,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wel_ok,
  input  logic             cs_rise,
  input  logic             aligned,
  input  logic             have_bytes,
  output logic             accept,
  output logic             filling,
  output logic             busy,
  output logic             last,
  output logic [CNT_W-1:0] phase
);
  pcb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(WR_CYCLES - 1));
  assign accept = start && wel_ok && (state_q != PCB_BUSY);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PCB_IDLE: if (accept) state_d = PCB_FILL;
      PCB_FILL: begin
        if (cs_rise) state_d = (aligned && have_bytes) ? PCB_BUSY : PCB_IDLE;
        else if (accept) state_d = PCB_FILL;
      end
      PCB_BUSY: if (at_end) state_d = PCB_IDLE;
      default:  state_d = PCB_IDLE;
    endcase
  end

  always_comb begin
    cnt_d = '0;
    if (state_q == PCB_BUSY && !at_end) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PCB_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign filling = (state_q == PCB_FILL);
  assign busy    = (state_q == PCB_BUSY);
  assign last    = busy && at_end;
  assign phase   = cnt_q;
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W    = 7,
  parameter int OFS_W     = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wel_state,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              bit_aligned,
  input  logic              cs_rise,
  input  logic              wren_cmd,
  input  logic              rd_cmd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic              wip,
  output logic              wel_set,
  output logic              wel_clr
);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int SLOTS = 1 << OFS_W;
  localparam int CNT_W = ($clog2(WR_CYCLES) > OFS_W) ? $clog2(WR_CYCLES) : OFS_W + 1;

  logic             rst_q_n;
  logic             accept, filling, busy, last;
  logic [CNT_W-1:0] phase;
  logic [OFS_W-1:0] wb_ofs;
  logic             wb_hit, any_hit, wb_window;
  logic [PG_W-1:0]  page_q, page_d;

  pcb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  pcb_commit_ctrl #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .start      (cmd_wr_start),
    .wel_ok     (wel_state),
    .cs_rise    (cs_rise),
    .aligned    (bit_aligned),
    .have_bytes (any_hit),
    .accept     (accept),
    .filling    (filling),
    .busy       (busy),
    .last       (last),
    .phase      (phase)
  );

  assign wb_ofs    = phase[OFS_W-1:0];
  assign wb_window = busy && (phase < CNT_W'(SLOTS));

  pcb_page_store #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clear     (accept),
    .start_ofs (cmd_addr[OFS_W-1:0]),
    .store     (byte_valid && filling && !cs_rise),
    .din       (byte_in),
    .rd_ofs    (wb_ofs),
    .dout      (mem_wdata),
    .rd_hit    (wb_hit),
    .any_hit   (any_hit)
  );

  assign page_d = accept ? cmd_addr[ADDR_W-1:OFS_W] : page_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) page_q <= '0;
    else          page_q <= page_d;
  end

  assign mem_we    = wb_window && wb_hit;
  assign mem_waddr = {page_q, wb_ofs};
  assign mem_re    = rd_cmd && !busy;
  assign wip       = busy;
  assign wel_set   = wren_cmd && !busy;
  assign wel_clr   = last;
endmodule

// File: rtl/pcb_chk.sv
module pcb_chk #(
  parameter int PG_W      = 3,
  parameter int WR_CYCLES = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_rise,
  input logic            bit_aligned,
  input logic            rd_cmd,
  input logic            mem_we,
  input logic [PG_W-1:0] page,
  input logic            mem_re,
  input logic            wip,
  input logic            wel_set,
  input logic            wel_clr
);
  localparam int RUN_W = $clog2(WR_CYCLES + 1) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_q <= '0;
    else if (wip) run_q <= run_q + 1'b1;
    else          run_q <= '0;
  end

  // R11
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip);
  // R9
  rd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !mem_re);
  // R9
  rd_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wip && rd_cmd) |-> mem_re);
  // R10
  wren_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !wel_set);
  // R4
  busy_needs_aligned_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise && bit_aligned));
  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run_q == RUN_W'(WR_CYCLES)));
  // R8
  clr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> wip);
  // R8
  clr_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wip);
  // R6
  page_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> $stable(page));
endmodule

bind page_commit_buf pcb_chk #(.PG_W(ADDR_W - OFS_W), .WR_CYCLES(WR_CYCLES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .cs_rise     (cs_rise),
  .bit_aligned (bit_aligned),
  .rd_cmd      (rd_cmd),
  .mem_we      (mem_we),
  .page        (mem_waddr[ADDR_W-1:OFS_W]),
  .mem_re      (mem_re),
  .wip         (wip),
  .wel_set     (wel_set),
  .wel_clr     (wel_clr)
);

// File: tb/page_commit_buf_tb_top.sv
module page_commit_buf_tb_top;
  localparam int WRC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr_start = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic       wel_state = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic       bit_aligned = 1'b0;
  logic       cs_rise = 1'b0;
  logic       wren_cmd = 1'b0;
  logic       rd_cmd = 1'b0;
  logic       mem_we, mem_re, wip, wel_set, wel_clr;
  logic [6:0] mem_waddr;
  logic [7:0] mem_wdata;

  typedef struct { logic [6:0] a; logic [7:0] d; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_bad = 0;
  int exp_runs = 0, seen_runs = 0;
  int run_len = 0, clr_cnt = 0;
  bit done = 1'b0;

  page_commit_buf #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr_start(cmd_wr_start), .cmd_addr(cmd_addr),
    .wel_state(wel_state), .byte_valid(byte_valid), .byte_in(byte_in),
    .bit_aligned(bit_aligned), .cs_rise(cs_rise), .wren_cmd(wren_cmd), .rd_cmd(rd_cmd),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .wip(wip), .wel_set(wel_set), .wel_clr(wel_clr)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Monitor: pops expected writes, tracks busy windows (R6, R3, R7, R8, R11)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_we) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected write", int'(mem_waddr), 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(mem_waddr == e.a, "R6 write address", int'(mem_waddr), int'(e.a));
          check(mem_wdata == e.d, "R3 write data", int'(mem_wdata), int'(e.d));
          check(wip, "R11 write outside busy", int'(wip), 1);
        end
      end
      if (wip) begin
        run_len++;
        if (wel_clr) begin
          clr_cnt++;
          check(run_len == WRC, "R8 clear position", run_len, WRC);
        end
      end else if (run_len > 0) begin
        check(run_len == WRC, "R7 busy length", run_len, WRC);
        check(clr_cnt == 1, "R8 clear count", clr_cnt, 1);
        seen_runs++;
        run_len = 0;
        clr_cnt = 0;
      end
    end
  end

  // Driver: runs one write command and computes the expected array writes
  task automatic send_cmd(input logic [6:0] a, input logic wel, input int n,
                          input logic [7:0] seed, input logic aligned);
    logic [7:0] mb [16];
    bit         mk [16];
    logic [3:0] ofs;
    bit         commit;
    for (int k = 0; k < 16; k++) begin mb[k] = '0; mk[k] = 1'b0; end
    ofs = a[3:0];
    @(posedge clk); #1;
    cmd_wr_start = 1'b1; cmd_addr = a; wel_state = wel;
    @(posedge clk); #1;
    cmd_wr_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1;
      byte_in = 8'(seed + 8'(i * 7));
      mb[ofs] = byte_in; mk[ofs] = 1'b1; ofs = ofs + 1'b1;
      @(posedge clk); #1;
      byte_valid = 1'b0;
      @(posedge clk); #1;
    end
    commit = wel && aligned && (n > 0);
    bit_aligned = aligned; cs_rise = 1'b1;
    @(posedge clk); #1;
    cs_rise = 1'b0; bit_aligned = 1'b0;
    if (commit) begin
      exp_runs++;
      for (int k = 0; k < 16; k++)
        if (mk[k]) exp_q.push_back('{a: {a[6:4], 4'(k)}, d: mb[k]});
    end
    @(negedge clk);
    check(wip == commit, commit ? "R7 busy start" :
          (!wel ? "R2 no busy" : (n == 0 ? "R5 no busy" : "R4 no busy")),
          int'(wip), int'(commit));
  endtask

  task automatic settle();
    repeat (WRC + 8) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R6 pending writes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!wip && !mem_we && !wel_clr, "R1 reset outputs", {wip, mem_we, wel_clr}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!wip && !mem_we && !wel_clr, "R1 after release", {wip, mem_we, wel_clr}, 0);

    // R9, R10 idle pass-through
    @(posedge clk); #1 rd_cmd = 1'b1; wren_cmd = 1'b1;
    @(negedge clk);
    check(mem_re, "R9 idle read", int'(mem_re), 1);
    check(wel_set, "R10 idle enable", int'(wel_set), 1);
    @(posedge clk); #1 rd_cmd = 1'b0; wren_cmd = 1'b0;

    send_cmd(7'h25, 1'b1, 1, 8'h3C, 1'b1); settle();      // single byte
    send_cmd(7'h38, 1'b1, 16, 8'h10, 1'b1); settle();     // full page, R3 wrap
    send_cmd(7'h5E, 1'b1, 20, 8'hA1, 1'b1); settle();     // R3 overwrite
    send_cmd(7'h7E, 1'b1, 3, 8'h55, 1'b1); settle();      // R6 sparse
    send_cmd(7'h12, 1'b0, 4, 8'h77, 1'b1); settle();      // R2
    send_cmd(7'h44, 1'b1, 5, 8'h90, 1'b0); settle();      // R4
    send_cmd(7'h60, 1'b1, 0, 8'h00, 1'b1); settle();      // R5

    // R9, R10: disturbances during a busy window
    send_cmd(7'h03, 1'b1, 2, 8'hE0, 1'b1);
    repeat (3) @(posedge clk); #1;
    rd_cmd = 1'b1; wren_cmd = 1'b1;
    @(negedge clk);
    check(!mem_re, "R9 busy read blocked", int'(mem_re), 0);
    check(!wel_set, "R10 busy enable blocked", int'(wel_set), 0);
    @(posedge clk); #1;
    rd_cmd = 1'b0; wren_cmd = 1'b0;
    cmd_wr_start = 1'b1; cmd_addr = 7'h10; wel_state = 1'b1;
    @(posedge clk); #1 cmd_wr_start = 1'b0; byte_valid = 1'b1; byte_in = 8'hCC;
    @(posedge clk); #1 byte_valid = 1'b0; cs_rise = 1'b1; bit_aligned = 1'b1;
    @(posedge clk); #1 cs_rise = 1'b0; bit_aligned = 1'b0;
    settle();
    send_cmd(7'h10, 1'b1, 0, 8'h00, 1'b1); settle();      // R10 no stale fill

    check(seen_runs == exp_runs, "R4 busy window count", seen_runs, exp_runs);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule